// File: doc/BRIEF.md
# Folded Linear-Phase FIR Filter

This block is a fixed-coefficient FIR filter for responses whose impulse response is mirror-symmetric or mirror-antisymmetric about its centre. Sample pairs that share a coefficient are added together, or subtracted in the antisymmetric mode, before they are multiplied. An N-tap filter therefore needs only ceil(N/2) multipliers. Across the pre-add stage and the summation tree it still uses N-1 adders, the same count as a plain direct form.

The filter is clocked from a fast system clock and is paced by a one-cycle sample strobe. Every tap, pre-add, product, tree and output register moves forward only in a clock cycle where the strobe is high. The pipeline depth therefore costs samples of latency, not clock cycles. Internal words grow far enough that no intermediate sum can wrap. The final result is rounded and then clamped to the output width.

Top module: `folded_fir`

## Requirements
- R1: While the strobe is low, no register advances, so `res_o` holds its value from one clock to the next.
- R2: `res_vld_o` is high only in the clock cycle that directly follows a strobe cycle. It is never high in any other cycle.
- R3: Let LAT = 3 + max(1, ceil(log2(ceil(NTAPS/2)))), which is 5 with the defaults. The first `res_vld_o` after reset comes with strobe number LAT+1. From then on, the k-th valid result (counting from 0) is the filter output for the k-th sample accepted since reset.
- R4: In symmetric mode (MODE = FOLD_SYM), a unit impulse gives back the coefficients h[0..N-1] in order, with h[N-1-k] = h[k]. For the defaults these are 3, -11, 37, 64, 37, -11, 3. Coefficient k sits in bits [k*CW +: CW] of `COEFS`.
- R5: In antisymmetric mode (MODE = FOLD_ANTI), each pre-add takes the difference of its pair, so h[N-1-k] = -h[k]. When N is odd, the centre tap gives zero.
- R6: A constant input A settles to A times the sum of the coefficients. For the defaults this is 12200 for A = 100 in symmetric mode and 0 in antisymmetric mode.
- R7: The filter is linear. For inputs in range, the response to 3*x1 - 2*x2 equals 3*y1 - 2*y2.
- R8: Results beyond the signed OW-bit range clamp to 2^(OW-1)-1 or -2^(OW-1) and never wrap.
- R9: With SHIFT > 0, the result is floor((acc + 2^(SHIFT-1)) / 2^SHIFT), which is round-half-up, and it is then clamped as in R8.
- R10: Every bit of `smp_i`, including the sign bit, reaches the result with its correct weight.
- R11: Reset clears every tap and pipeline register. `res_o` reads 0 and `res_vld_o` reads 0 during reset, and samples taken before reset have no effect on any result after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may run far above the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle strobe that marks a new sample |
| smp_i | input | DW | Signed input sample |
| res_o | output | OW | Signed filtered result, rounded and clamped |
| res_vld_o | output | 1 | One-clock pulse when a result leaves the pipeline |

## Verification
The assertions check the strobe timing on every clock. They confirm that the result stays frozen between strobes, that the valid pulse appears only after a strobe, that it first appears on exactly the right strobe after reset, and that the clamp engages whenever the accumulator has left the output range. Numerical correctness can only be shown by the bench scenarios. These cover the impulse sequences in both modes, the step sums, the superposition test, the walking-bit inputs, rounding, and clearing of the taps by a mid-stream reset. The bench compares every result against an independent software model.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic {
    FOLD_SYM  = 1'b0,
    FOLD_ANTI = 1'b1
  } fold_mode_e;

  localparam int unsigned DEF_NTAPS = 7;
  localparam int unsigned DEF_CW    = 10;

  // Outer tap first: coefficient k occupies bits [k*CW +: CW]
  localparam logic [4*DEF_CW-1:0] DEF_COEFS = {10'sd64, 10'sd37, -10'sd11, 10'sd3};

endpackage

// File: rtl/fir_fold_taps.sv
module fir_fold_taps
  import fir_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned NTAPS = 7,
  parameter fold_mode_e  MODE  = FOLD_SYM,
  localparam int unsigned NHALF = (NTAPS + 1) / 2,
  localparam int unsigned NPAIR = NTAPS / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] smp_i,
  output logic signed [DW:0]   pre_o [NHALF]
);

  logic signed [DW-1:0] tap_q [NTAPS];

  function automatic logic signed [DW:0] ext(input logic signed [DW-1:0] v);
    return {v[DW-1], v};
  endfunction

  // delay line, advances on the sample strobe only
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
    end else if (en) begin
      tap_q[0] <= smp_i;
      for (int i = 1; i < NTAPS; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  // pre-add stage: one adder or subtractor per mirrored pair
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NHALF; k++) pre_o[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NPAIR; k++) begin
        if (MODE == FOLD_ANTI) pre_o[k] <= ext(tap_q[k]) - ext(tap_q[NTAPS-1-k]);
        else                   pre_o[k] <= ext(tap_q[k]) + ext(tap_q[NTAPS-1-k]);
      end
      if (NTAPS % 2 == 1) begin
        if (MODE == FOLD_ANTI) pre_o[NHALF-1] <= '0;
        else                   pre_o[NHALF-1] <= ext(tap_q[NHALF-1]);
      end
    end
  end

endmodule

// File: rtl/fir_products.sv
module fir_products #(
  parameter int unsigned NHALF = 4,
  parameter int unsigned PW    = 13,
  parameter int unsigned CW    = 10,
  parameter logic [NHALF*CW-1:0] COEFS = '0,
  localparam int unsigned MW   = PW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [PW-1:0] pre_i  [NHALF],
  output logic signed [MW-1:0] prod_o [NHALF]
);

  function automatic logic signed [CW-1:0] coef(input int k);
    return COEFS[k*CW +: CW];
  endfunction

  // one shared multiplier per coefficient
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NHALF; k++) prod_o[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NHALF; k++) prod_o[k] <= MW'(pre_i[k]) * MW'(coef(k));
    end
  end

endmodule

// File: rtl/fir_sum_tree.sv
module fir_sum_tree #(
  parameter int unsigned NIN = 4,
  parameter int unsigned IW  = 23,
  parameter int unsigned OW  = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] term_i [NIN],
  output logic signed [OW-1:0] sum_o
);

  localparam int LVLS  = (NIN > 1) ? $clog2(NIN) : 1;
  localparam int NP2   = 1 << LVLS;
  localparam int NNODE = NP2 - 1;
  localparam int NALL  = 2 * NP2 - 1;
  localparam int NINI  = NIN;

  logic signed [OW-1:0] node_q [NNODE];
  logic signed [OW-1:0] all_w  [NALL];

  // heap layout: node i sums children 2i+1 and 2i+2, leaves follow the nodes
  always_comb begin
    for (int i = 0; i < NALL; i++) begin
      if (i < NNODE)             all_w[i] = node_q[i];
      else if (i - NNODE < NINI) all_w[i] = OW'(term_i[i-NNODE]);
      else                       all_w[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NNODE; i++) node_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < NNODE; i++) node_q[i] <= all_w[2*i+1] + all_w[2*i+2];
    end
  end

  assign sum_o = all_w[0];

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
  parameter int unsigned IW    = 26,
  parameter int unsigned OW    = 16,
  parameter int unsigned SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] acc_i,
  output logic signed [OW-1:0] res_o
);

  localparam int unsigned TW = IW + 1;
  localparam logic signed [TW-1:0] HALF = TW'((64'sd1 <<< SHIFT) >>> 1);
  localparam logic signed [TW-1:0] MAXV = TW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [TW-1:0] MINV = TW'(-(64'sd1 <<< (OW - 1)));

  logic signed [TW-1:0] biased_w;
  logic signed [TW-1:0] scaled_w;

  assign biased_w = TW'(acc_i) + HALF;
  assign scaled_w = biased_w >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
    end else if (en) begin
      if (scaled_w > MAXV)      res_o <= MAXV[OW-1:0];
      else if (scaled_w < MINV) res_o <= MINV[OW-1:0];
      else                      res_o <= scaled_w[OW-1:0];
    end
  end

endmodule

// File: rtl/folded_fir.sv
module folded_fir
  import fir_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CW    = DEF_CW,
  parameter int unsigned NTAPS = DEF_NTAPS,
  parameter fold_mode_e  MODE  = FOLD_SYM,
  parameter logic [((NTAPS+1)/2)*CW-1:0] COEFS = DEF_COEFS,
  parameter int unsigned OW    = 16,
  parameter int unsigned SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic signed [DW-1:0] smp_i,
  output logic signed [OW-1:0] res_o,
  output logic                 res_vld_o
);

  localparam int unsigned NHALF = (NTAPS + 1) / 2;
  localparam int unsigned PW    = DW + 1;
  localparam int unsigned MW    = PW + CW;
  localparam int unsigned ACCW  = MW + $clog2(NTAPS);
  localparam int unsigned LVLS  = (NHALF > 1) ? $clog2(NHALF) : 1;
  localparam int unsigned LAT   = 3 + LVLS;
  localparam int unsigned CNTW  = $clog2(LAT + 1);
  localparam logic [CNTW-1:0] LAT_C = CNTW'(LAT);

  logic signed [PW-1:0]   pre_w  [NHALF];
  logic signed [MW-1:0]   prod_w [NHALF];
  logic signed [ACCW-1:0] acc_w;
  logic [CNTW-1:0]        fill_q;

  fir_fold_taps #(.DW(DW), .NTAPS(NTAPS), .MODE(MODE)) u_taps (
    .clk(clk), .rst(rst), .en(smp_en), .smp_i(smp_i), .pre_o(pre_w)
  );

  fir_products #(.NHALF(NHALF), .PW(PW), .CW(CW), .COEFS(COEFS)) u_mul (
    .clk(clk), .rst(rst), .en(smp_en), .pre_i(pre_w), .prod_o(prod_w)
  );

  fir_sum_tree #(.NIN(NHALF), .IW(MW), .OW(ACCW)) u_tree (
    .clk(clk), .rst(rst), .en(smp_en), .term_i(prod_w), .sum_o(acc_w)
  );

  fir_round_sat #(.IW(ACCW), .OW(OW), .SHIFT(SHIFT)) u_out (
    .clk(clk), .rst(rst), .en(smp_en), .acc_i(acc_w), .res_o(res_o)
  );

  // strobes seen since reset, saturating once the pipeline is full
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= smp_en && (fill_q == LAT_C);
      if (smp_en && fill_q != LAT_C) fill_q <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
  parameter int unsigned OW    = 16,
  parameter int unsigned LAT   = 5,
  parameter int unsigned ACCW  = 26,
  parameter int unsigned SHIFT = 0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   smp_en,
  input logic signed [OW-1:0]   res_o,
  input logic                   res_vld_o,
  input logic signed [ACCW-1:0] acc_i
);

  localparam int unsigned SW = $clog2(LAT + 2);
  localparam logic [SW-1:0] LAT_S = SW'(LAT);
  localparam logic signed [ACCW-1:0] MAXA = ACCW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] MINA = ACCW'(-(64'sd1 <<< (OW - 1)));
  localparam logic signed [OW-1:0]   MAXO = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0]   MINO = {1'b1, {(OW-1){1'b0}}};

  logic [SW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (smp_en && seen_q <= LAT_S) seen_q <= seen_q + 1'b1;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(smp_en) |-> $stable(res_o)); // R1

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(smp_en) |-> !res_vld_o); // R2

  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(smp_en) |-> (res_vld_o == (seen_q > LAT_S))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(smp_en) && (($past(acc_i) >>> SHIFT) > MAXA) |-> res_o == MAXO); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(smp_en) && (($past(acc_i) >>> SHIFT) < MINA) |-> res_o == MINO); // R8

endmodule

bind folded_fir fir_chk #(.OW(OW), .LAT(LAT), .ACCW(ACCW), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .res_o(res_o),
  .res_vld_o(res_vld_o), .acc_i(acc_w)
);

// File: tb/folded_fir_tb.sv
module folded_fir_tb;
  import fir_pkg::*;

  localparam int NT   = 7;
  localparam int LATB = 5;

  typedef struct packed { int val; int reps; int req; int mark; } stim_t;
  localparam int NSTIM = 34;
  localparam stim_t STIM [NSTIM] = '{
    '{1, 1, 4, 0}, '{0, 7, 4, 0},                                   // R4 R5 impulse
    '{100, 8, 6, 1}, '{0, 7, 6, 0},                                 // R6 step
    '{5, 1, 7, 2}, '{-3, 1, 7, 0}, '{7, 1, 7, 0}, '{2, 1, 7, 0}, '{0, 7, 7, 0},    // R7 x1
    '{-4, 1, 7, 3}, '{9, 1, 7, 0}, '{1, 1, 7, 0}, '{6, 1, 7, 0}, '{0, 7, 7, 0},    // R7 x2
    '{23, 1, 7, 4}, '{-27, 1, 7, 0}, '{19, 1, 7, 0}, '{-6, 1, 7, 0}, '{0, 7, 7, 0}, // R7 3*x1-2*x2
    '{1, 1, 10, 0}, '{2, 1, 10, 0}, '{4, 1, 10, 0}, '{8, 1, 10, 0},  // R10 walking bit
    '{16, 1, 10, 0}, '{32, 1, 10, 0}, '{64, 1, 10, 0}, '{128, 1, 10, 0},
    '{256, 1, 10, 0}, '{512, 1, 10, 0}, '{1024, 1, 10, 0}, '{-2048, 1, 10, 0},
    '{2047, 8, 8, 5}, '{-2048, 8, 8, 6},                            // R8 clamp
    '{0, 8, 3, 0}                                                   // R3 flush
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [11:0] din = '0;
  logic signed [15:0] y_s, y_a, y_r;
  logic v_s, v_a, v_r;

  int errors = 0, checks = 0;
  int xs [256];
  int reqs [256];
  int nx = 0;
  int marks [8];
  int ys_s [256], ys_a [256], ys_r [256];
  int vc_s = 0, vc_a = 0, vc_r = 0;
  int strobe_cnt = 0;
  bit en_q = 1'b0, rst_q = 1'b1;
  int first_at = -1;
  int hold_bad = 0, vld_bad = 0;
  int prev_s = 0;
  int base;

  always #5 clk = ~clk;

  folded_fir #(.MODE(FOLD_SYM)) u_dut (
    .clk(clk), .rst(rst), .smp_en(en), .smp_i(din), .res_o(y_s), .res_vld_o(v_s));
  folded_fir #(.MODE(FOLD_ANTI)) u_dut_as (
    .clk(clk), .rst(rst), .smp_en(en), .smp_i(din), .res_o(y_a), .res_vld_o(v_a));
  folded_fir #(.MODE(FOLD_SYM), .SHIFT(2)) u_dut_rs (
    .clk(clk), .rst(rst), .smp_en(en), .smp_i(din), .res_o(y_r), .res_vld_o(v_r));

  function automatic int coef(int k, bit anti);
    int m, r;
    if (k == NT / 2) return anti ? 0 : 64;
    m = (k < NT / 2) ? k : NT - 1 - k;
    case (m)
      0:       r = 3;
      1:       r = -11;
      default: r = 37;
    endcase
    if (anti && k > NT / 2) r = -r;
    return r;
  endfunction

  function automatic longint model(int n, bit anti, int sh);
    longint acc = 0;
    for (int k = 0; k < NT; k++)
      if (n - k >= 0) acc += longint'(coef(k, anti)) * longint'(xs[n-k]);
    if (sh > 0) acc = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int v);
    @(negedge clk);
    din = 12'(v);
    en  = 1'b1;
    xs[nx] = v;
    nx++;
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    en_q  <= en;
    rst_q <= rst;
    if (rst) strobe_cnt <= 0;
    else if (en) strobe_cnt <= strobe_cnt + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      first_at = -1;
    end else begin
      if (v_s) begin ys_s[vc_s] = y_s; vc_s++; if (first_at < 0) first_at = strobe_cnt; end
      if (v_a) begin ys_a[vc_a] = y_a; vc_a++; end
      if (v_r) begin ys_r[vc_r] = y_r; vc_r++; end
      if (!rst_q && !en_q) begin
        if (int'(y_s) != prev_s) hold_bad++;   // R1
        if (v_s || v_a || v_r)   vld_bad++;    // R2
      end
    end
    prev_s = y_s;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R11", y_s, 0, "result during reset");
    check("R11", v_s, 0, "valid during reset");
    @(negedge clk);
    rst = 1'b0;

    for (int e = 0; e < NSTIM; e++) begin
      if (STIM[e].mark != 0) marks[STIM[e].mark] = nx;
      for (int r = 0; r < STIM[e].reps; r++) begin
        reqs[nx] = STIM[e].req;
        push(STIM[e].val);
      end
    end
    repeat (4) @(negedge clk);
    #1;

    check("R3", first_at, LATB + 1, "strobe carrying first valid");
    check("R3", vc_s, nx - LATB, "valid count symmetric");
    check("R3", vc_a, nx - LATB, "valid count antisymmetric");
    for (int k = 0; k < vc_s; k++)
      check($sformatf("R%0d", reqs[k]), ys_s[k], model(k, 1'b0, 0), $sformatf("sym sample %0d", k));
    for (int k = 0; k < vc_a; k++)
      check("R5", ys_a[k], model(k, 1'b1, 0), $sformatf("anti sample %0d", k));
    for (int k = 0; k < vc_r; k++)
      check("R9", ys_r[k], model(k, 1'b0, 2), $sformatf("rounded sample %0d", k));

    for (int k = 0; k < NT; k++) begin
      check("R4", ys_s[k], coef(k, 1'b0), $sformatf("impulse tap %0d", k));
      check("R5", ys_a[k], coef(k, 1'b1), $sformatf("anti impulse tap %0d", k));
    end
    check("R5", ys_a[NT/2], 0, "anti centre tap");
    check("R6", ys_s[marks[1] + 7], 12200, "step settle sym");
    check("R6", ys_a[marks[1] + 7], 0, "step settle anti");
    check("R9", ys_r[marks[1] + 7], 3050, "step settle rounded");
    for (int j = 0; j < 11; j++)
      check("R7", ys_s[marks[4] + j], 3 * ys_s[marks[2] + j] - 2 * ys_s[marks[3] + j],
            $sformatf("superposition offset %0d", j));
    check("R8", ys_s[marks[5] + 7], 32767, "positive clamp");
    check("R8", ys_s[marks[6] + 7], -32768, "negative clamp");
    check("R1", hold_bad, 0, "result moved without strobe");
    check("R2", vld_bad, 0, "valid outside strobe follow-up");

    repeat (4) push(2047);
    repeat (2) @(negedge clk);
    #1;
    base = vc_s;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R11", y_s, 0, "result after mid-run reset");
    check("R11", v_s, 0, "valid after mid-run reset");
    @(negedge clk);
    rst = 1'b0;
    repeat (6) push(0);
    repeat (2) @(negedge clk);
    #1;
    check("R3", first_at, LATB + 1, "first valid strobe after reset");
    check("R11", vc_s, base + 1, "valid count after reset");
    check("R11", ys_s[base], 0, "cleared taps after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule